// File: doc/BRIEF.md
# Banked ROM Window Address Mapper

This block sits on an 8-bit CPU's 16-bit memory bus and turns two fixed ROM windows into views of larger paged flash. A 4 KB monitor window at the bottom of memory (0x0000–0x0FFF) shows one page chosen by a monitor bank register. A 2 KB user window (0xE800–0xEFFF) shows one page chosen by a user page register. A two-bit field in a control register picks which of three user flash devices receives the access. The block drives a shared flash address bus and one active-low chip select per device.

The top three bytes of the user window also hold three write-only registers. 0xEFFD is the monitor bank, 0xEFFE is the user page and 0xEFFF is control. Reads at these addresses still return flash data. A write takes effect only while the external unlock input is high; that input comes from a separate coded-latch block. The control register also drives the SD card select, the bit-bang SPI clock and data lines, and a 3-bit preset that goes back to the latch block.

Top module: `rom_bank_mapper`

## Requirements
- R1: After reset the monitor bank and the user page are 0, and `sd_cs_n` is 1. `bb_clk`, `bb_mosi`, `latch_preset` and the device select are all 0.
- R2: With `mreq_n` low and an address in 0x0000–0x0FFF, `mon_cs_n` is 0. `flash_addr` is {monitor bank bits 6:0, address bits 11:0}.
- R3: An address in 0xE800–0xEFFF places {user page, address bits 10:0} on `flash_addr`. With `mreq_n` low, the device chosen by control bits 7:6 gets an active-low select on `usr_cs_n`.
- R4: Control bits 7:6 select the user device as follows: 00 enables `usr_cs_n[0]`, 01 enables `usr_cs_n[1]`, 10 enables `usr_cs_n[2]`, and 11 enables none.
- R5: No chip select is active while `mreq_n` is high, or when the address lies outside both windows. Outside both windows, `flash_addr` is 0.
- R6: A write to a register is captured on the first clock edge at which `mreq_n` and `wr_n` are both low while `unlock` is 1. The new value shows on the outputs after that edge. The register addresses are 0xEFFD for the monitor bank, 0xEFFE for the user page and 0xEFFF for control.
- R7: Control bit 0 drives `bb_clk`, bit 1 drives `sd_cs_n` and bit 2 drives `bb_mosi`. Bits 5:3 drive `latch_preset`.
- R8: Register writes made while `unlock` is 0 leave every register unchanged.
- R9: Reads (`wr_n` high) in 0xEFF8–0xEFFF, including the register addresses, behave as ordinary user-window flash reads and never alter a register.
- R10: One strobe assertion writes at most once. Data that changes while the strobe stays low has no effect, and `wr_n` low with `mreq_n` high writes nothing.
- R11: Unlocked writes to 0xEFF8–0xEFFC change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| mreq_n | input | 1 | Memory request, active low |
| wr_n | input | 1 | Write, active low |
| unlock | input | 1 | Register write permission from the latch block |
| flash_addr | output | 19 | Flash address lines |
| mon_cs_n | output | 1 | Monitor flash select, active low |
| usr_cs_n | output | 3 | User flash device selects, active low |
| sd_cs_n | output | 1 | SD card select, active low |
| bb_clk | output | 1 | Bit-bang SPI clock |
| bb_mosi | output | 1 | Bit-bang SPI data out |
| latch_preset | output | 3 | Coded-latch preset to the latch block |

## Verification
The hardest case to reach is a write strobe that stays low over several clocks while the data bus changes. Only the first edge of the strobe may be captured. The stimulus holds `mreq_n` and `wr_n` low across two edges and changes the control data in between. It then checks that the outputs keep the first value.

A second hard case is a write to one of the unused addresses in the register region, and a read of a register address. For each, the stimulus then reads both windows and observes the page and device selection, to confirm that no register moved.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    localparam int REG_W  = 8;
    localparam int DSEL_W = 2;

    // Control register layout: bit 7 down to bit 0.
    typedef struct packed {
        logic [DSEL_W-1:0] dev_sel;   // bits 7:6
        logic [2:0]        preset;    // bits 5:3
        logic              mosi;      // bit 2
        logic              sd_cs_n;   // bit 1
        logic              bb_clk;    // bit 0
    } rbm_ctrl_t;

    localparam rbm_ctrl_t CTRL_RESET = '{dev_sel: '0, preset: '0, mosi: 1'b0,
                                         sd_cs_n: 1'b1, bb_clk: 1'b0};

    typedef struct packed {
        logic [REG_W-1:0] mon_bank;
        logic [REG_W-1:0] usr_page;
        rbm_ctrl_t        ctrl;
        logic             strobe_prev;
    } rbm_state_t;

endpackage

// File: rtl/rbm_decode.sv
module rbm_decode #(
    parameter int                ADDR_W   = 16,
    parameter int                MON_AW   = 12,
    parameter int                USR_AW   = 11,
    parameter logic [ADDR_W-1:0] MON_BASE = 16'h0000,
    parameter logic [ADDR_W-1:0] USR_BASE = 16'hE800
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mon_hit,
    output logic              usr_hit,
    output logic              reg_mon_hit,
    output logic              reg_page_hit,
    output logic              reg_ctl_hit
);
    localparam logic [ADDR_W-1:0] USR_TOP  = USR_BASE + ADDR_W'((1 << USR_AW) - 1);
    localparam logic [ADDR_W-1:0] CTL_ADDR = USR_TOP;
    localparam logic [ADDR_W-1:0] PG_ADDR  = USR_TOP - ADDR_W'(1);
    localparam logic [ADDR_W-1:0] MB_ADDR  = USR_TOP - ADDR_W'(2);

    always_comb begin
        mon_hit      = (addr[ADDR_W-1:MON_AW] == MON_BASE[ADDR_W-1:MON_AW]);
        usr_hit      = (addr[ADDR_W-1:USR_AW] == USR_BASE[ADDR_W-1:USR_AW]);
        reg_mon_hit  = (addr == MB_ADDR);
        reg_page_hit = (addr == PG_ADDR);
        reg_ctl_hit  = (addr == CTL_ADDR);
    end
endmodule

// File: rtl/rbm_regs.sv
module rbm_regs
    import rbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             unlock,
    input  logic             reg_mon_hit,
    input  logic             reg_page_hit,
    input  logic             reg_ctl_hit,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mon_bank,
    output logic [REG_W-1:0] usr_page,
    output rbm_ctrl_t        ctrl
);
    rbm_state_t st_d, st_q;
    logic       wr_edge_d;

    always_comb begin
        st_d             = st_q;
        st_d.strobe_prev = strobe;
        wr_edge_d        = strobe && !st_q.strobe_prev && unlock;
        if (wr_edge_d) begin
            if (reg_mon_hit)  st_d.mon_bank = wdata;
            if (reg_page_hit) st_d.usr_page = wdata;
            if (reg_ctl_hit)  st_d.ctrl     = rbm_ctrl_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mon_bank    <= '0;
            st_q.usr_page    <= '0;
            st_q.ctrl        <= CTRL_RESET;
            st_q.strobe_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mon_bank = st_q.mon_bank;
    assign usr_page = st_q.usr_page;
    assign ctrl     = st_q.ctrl;
endmodule

// File: rtl/rbm_route.sv
module rbm_route
    import rbm_pkg::*;
#(
    parameter int MON_AW       = 12,
    parameter int USR_AW       = 11,
    parameter int MON_BANK_USE = 7,
    parameter int NUM_DEV      = 3,
    parameter int FLASH_AW     = 19
) (
    input  logic                    req,
    input  logic                    mon_hit,
    input  logic                    usr_hit,
    input  logic [MON_AW-1:0]       addr_lo,
    input  logic [MON_BANK_USE-1:0] mon_bank,
    input  logic [REG_W-1:0]        usr_page,
    input  logic [DSEL_W-1:0]       dev_sel,
    output logic [FLASH_AW-1:0]     flash_addr,
    output logic                    mon_cs_n,
    output logic [NUM_DEV-1:0]      usr_cs_n
);
    always_comb begin
        flash_addr = '0;
        if (mon_hit) begin
            flash_addr[MON_AW-1:0]            = addr_lo;
            flash_addr[MON_AW +: MON_BANK_USE] = mon_bank;
        end else if (usr_hit) begin
            flash_addr[USR_AW-1:0]      = addr_lo[USR_AW-1:0];
            flash_addr[USR_AW +: REG_W] = usr_page;
        end
    end

    assign mon_cs_n = ~(req & mon_hit);

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign usr_cs_n[i] = ~(req && usr_hit && (dev_sel == DSEL_W'(i)));
    end
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
    import rbm_pkg::*;
#(
    parameter int      ADDR_W       = 16,
    parameter int      MON_AW       = 12,
    parameter int      USR_AW       = 11,
    parameter int      MON_BANK_USE = 7,
    parameter int      NUM_DEV      = 3,
    parameter logic [15:0] MON_BASE = 16'h0000,
    parameter logic [15:0] USR_BASE = 16'hE800,
    localparam int     FLASH_AW     = ((MON_BANK_USE + MON_AW) > (REG_W + USR_AW)) ?
                                      (MON_BANK_USE + MON_AW) : (REG_W + USR_AW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [REG_W-1:0]    cpu_wdata,
    input  logic                mreq_n,
    input  logic                wr_n,
    input  logic                unlock,
    output logic [FLASH_AW-1:0] flash_addr,
    output logic                mon_cs_n,
    output logic [NUM_DEV-1:0]  usr_cs_n,
    output logic                sd_cs_n,
    output logic                bb_clk,
    output logic                bb_mosi,
    output logic [2:0]          latch_preset
);
    logic             mon_hit, usr_hit, r_mon, r_page, r_ctl;
    logic             req, strobe;
    logic [REG_W-1:0] mon_bank, usr_page;
    rbm_ctrl_t        ctrl;

    assign req    = ~mreq_n;
    assign strobe = ~mreq_n & ~wr_n;

    rbm_decode #(
        .ADDR_W(ADDR_W), .MON_AW(MON_AW), .USR_AW(USR_AW),
        .MON_BASE(ADDR_W'(MON_BASE)), .USR_BASE(ADDR_W'(USR_BASE))
    ) u_decode (
        .addr(cpu_addr), .mon_hit(mon_hit), .usr_hit(usr_hit),
        .reg_mon_hit(r_mon), .reg_page_hit(r_page), .reg_ctl_hit(r_ctl)
    );

    rbm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .unlock(unlock),
        .reg_mon_hit(r_mon), .reg_page_hit(r_page), .reg_ctl_hit(r_ctl),
        .wdata(cpu_wdata), .mon_bank(mon_bank), .usr_page(usr_page), .ctrl(ctrl)
    );

    rbm_route #(
        .MON_AW(MON_AW), .USR_AW(USR_AW), .MON_BANK_USE(MON_BANK_USE),
        .NUM_DEV(NUM_DEV), .FLASH_AW(FLASH_AW)
    ) u_route (
        .req(req), .mon_hit(mon_hit), .usr_hit(usr_hit),
        .addr_lo(cpu_addr[MON_AW-1:0]), .mon_bank(mon_bank[MON_BANK_USE-1:0]),
        .usr_page(usr_page), .dev_sel(ctrl.dev_sel),
        .flash_addr(flash_addr), .mon_cs_n(mon_cs_n), .usr_cs_n(usr_cs_n)
    );

    assign sd_cs_n      = ctrl.sd_cs_n;
    assign bb_clk       = ctrl.bb_clk;
    assign bb_mosi      = ctrl.mosi;
    assign latch_preset = ctrl.preset;
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
    parameter int          NUM_DEV  = 3,
    parameter int          FLASH_AW = 19,
    parameter logic [15:0] CTL_ADDR = 16'hEFFF
) (
    input logic                clk,
    input logic                rst_n,
    input logic [15:0]         cpu_addr,
    input logic [7:0]          cpu_wdata,
    input logic                mreq_n,
    input logic                wr_n,
    input logic                unlock,
    input logic [FLASH_AW-1:0] flash_addr,
    input logic                mon_cs_n,
    input logic [NUM_DEV-1:0]  usr_cs_n,
    input logic                sd_cs_n,
    input logic                bb_clk,
    input logic                bb_mosi,
    input logic [2:0]          latch_preset
);
    assert_cs_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{usr_cs_n, mon_cs_n}));

    assert_idle_no_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |-> (mon_cs_n && (&usr_cs_n)));

    assert_mon_low_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:12] == 4'h0) |-> (flash_addr[11:0] == cpu_addr[11:0]));

    assert_locked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |=> ($stable(sd_cs_n) && $stable(bb_clk) && $stable(bb_mosi)
                     && $stable(latch_preset)));

    assert_no_strobe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_n || wr_n) |=> ($stable(sd_cs_n) && $stable(bb_clk) && $stable(bb_mosi)
                              && $stable(latch_preset)));

    assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(!mreq_n && !wr_n) && unlock && (cpu_addr == CTL_ADDR)) |=>
        ({latch_preset, bb_mosi, sd_cs_n, bb_clk} == $past(cpu_wdata[5:0])));
endmodule

bind rom_bank_mapper rbm_checker #(
    .NUM_DEV(NUM_DEV), .FLASH_AW(FLASH_AW),
    .CTL_ADDR(16'(USR_BASE + 16'((1 << USR_AW) - 1)))
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(16'(cpu_addr)), .cpu_wdata(cpu_wdata),
    .mreq_n(mreq_n), .wr_n(wr_n), .unlock(unlock), .flash_addr(flash_addr),
    .mon_cs_n(mon_cs_n), .usr_cs_n(usr_cs_n), .sd_cs_n(sd_cs_n), .bb_clk(bb_clk),
    .bb_mosi(bb_mosi), .latch_preset(latch_preset)
);

// File: tb/rom_bank_mapper_bench.sv
module rom_bank_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h1000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        mreq_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        unlock = 1'b0;
    logic [18:0] flash_addr;
    logic        mon_cs_n, sd_cs_n, bb_clk, bb_mosi;
    logic [2:0]  usr_cs_n, latch_preset;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rom_bank_mapper u_rom_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .mreq_n(mreq_n), .wr_n(wr_n), .unlock(unlock), .flash_addr(flash_addr),
        .mon_cs_n(mon_cs_n), .usr_cs_n(usr_cs_n), .sd_cs_n(sd_cs_n),
        .bb_clk(bb_clk), .bb_mosi(bb_mosi), .latch_preset(latch_preset)
    );

    typedef struct {
        logic [18:0] fa;
        logic        mcs;
        logic [2:0]  ucs;
        logic [5:0]  ctl_lo;
        string       tag;
    } exp_t;

    exp_t q[$];

    // Reference model state, built from the requirements.
    logic [7:0] m_bank = 8'h00;
    logic [7:0] m_page = 8'h00;
    logic [7:0] m_ctrl = 8'h02;
    bit         m_prev = 1'b0;

    task automatic cyc(input logic [15:0] a, input bit mreq, input bit wr,
                       input logic [7:0] d, input bit unl, input string tag);
        exp_t e;
        bit   stb;
        @(negedge clk);
        cpu_addr = a; mreq_n = ~mreq; wr_n = ~wr; cpu_wdata = d; unlock = unl;
        stb = mreq && wr;
        if (stb && !m_prev && unl) begin
            if (a == 16'hEFFD) m_bank = d;
            if (a == 16'hEFFE) m_page = d;
            if (a == 16'hEFFF) m_ctrl = d;
        end
        m_prev = stb;
        e.fa  = '0;
        e.mcs = 1'b1;
        e.ucs = 3'b111;
        if (a[15:12] == 4'h0) begin
            e.fa  = {m_bank[6:0], a[11:0]};
            e.mcs = ~mreq;
        end else if (a[15:11] == 5'b11101) begin
            e.fa = {m_page, a[10:0]};
            if (mreq && m_ctrl[7:6] != 2'b11) e.ucs[m_ctrl[7:6]] = 1'b0;
        end
        e.ctl_lo = m_ctrl[5:0];
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare two time units after each rising edge.
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (flash_addr !== e.fa || mon_cs_n !== e.mcs || usr_cs_n !== e.ucs ||
                    {latch_preset, bb_mosi, sd_cs_n, bb_clk} !== e.ctl_lo) begin
                    errors++;
                    $display("FAIL %s: got fa=%h mcs=%b ucs=%b ctl=%b, expected fa=%h mcs=%b ucs=%b ctl=%b",
                             e.tag, flash_addr, mon_cs_n, usr_cs_n,
                             {latch_preset, bb_mosi, sd_cs_n, bb_clk},
                             e.fa, e.mcs, e.ucs, e.ctl_lo);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(16'h1000, 0, 0, 8'h00, 0, "R1 reset state");
        cyc(16'h0ABC, 1, 0, 8'h00, 0, "R2 monitor read bank 0");
        cyc(16'hE9A5, 1, 0, 8'h00, 0, "R3 user read page 0 dev 0");
        // Locked writes
        cyc(16'hEFFD, 1, 1, 8'h05, 0, "R8 locked monitor bank write");
        cyc(16'h1000, 0, 0, 8'h00, 0, "R8 idle");
        cyc(16'hEFFF, 1, 1, 8'hC5, 0, "R8 locked ctrl write");
        cyc(16'h0123, 1, 0, 8'h00, 0, "R8 monitor bank unchanged");
        // Unlocked writes
        cyc(16'hEFFD, 1, 1, 8'h85, 1, "R6 monitor bank write");
        cyc(16'h0FFF, 1, 0, 8'h00, 1, "R2 monitor read bank 5 top");
        cyc(16'hEFFE, 1, 1, 8'h3C, 1, "R6 user page write");
        cyc(16'hEFF8, 1, 0, 8'h00, 1, "R9 read register region");
        cyc(16'hEFFF, 1, 1, 8'h07, 1, "R7 ctrl write 07");
        cyc(16'h1000, 0, 0, 8'h00, 1, "R7 idle");
        cyc(16'hEFFF, 1, 1, 8'h2A, 1, "R7 ctrl write 2A");
        cyc(16'hE800, 1, 0, 8'h00, 1, "R3 user read bottom");
        // Device select encodings
        cyc(16'hEFFF, 1, 1, 8'h40, 1, "R4 select dev 1");
        cyc(16'hEC00, 1, 0, 8'h00, 1, "R4 dev 1 read");
        cyc(16'hEFFF, 1, 1, 8'h80, 1, "R4 select dev 2");
        cyc(16'hEC00, 1, 0, 8'h00, 1, "R4 dev 2 read");
        cyc(16'hEFFF, 1, 1, 8'hC0, 1, "R4 select none");
        cyc(16'hEC00, 1, 0, 8'h00, 1, "R4 no device read");
        cyc(16'h0400, 1, 0, 8'h00, 1, "R4 monitor still works");
        // Unused addresses in the register region
        cyc(16'hEFFB, 1, 1, 8'h11, 1, "R11 write EFFB");
        cyc(16'h1000, 0, 0, 8'h00, 1, "R11 idle");
        cyc(16'hEFFC, 1, 1, 8'h22, 1, "R11 write EFFC");
        cyc(16'h1000, 0, 0, 8'h00, 1, "R11 idle");
        cyc(16'hEFF8, 1, 1, 8'h33, 1, "R11 write EFF8");
        cyc(16'hEABC, 1, 0, 8'h00, 1, "R11 page unchanged");
        cyc(16'h0ABC, 1, 0, 8'h00, 1, "R11 bank unchanged");
        // Reads of register addresses
        cyc(16'hEFFF, 1, 1, 8'h02, 1, "R6 ctrl back to dev 0");
        cyc(16'hEFFD, 1, 0, 8'h7F, 1, "R9 read monitor bank address");
        cyc(16'hEFFE, 1, 0, 8'h7F, 1, "R9 read page address");
        cyc(16'h0100, 1, 0, 8'h00, 1, "R9 bank unchanged after read");
        // Held strobe with data change
        cyc(16'hEFFF, 1, 1, 8'h01, 1, "R10 held strobe first edge");
        cyc(16'hEFFF, 1, 1, 8'h06, 1, "R10 held strobe data change");
        cyc(16'hEFFF, 1, 1, 8'h3F, 1, "R10 held strobe third edge");
        cyc(16'h1000, 0, 0, 8'h00, 1, "R10 release");
        cyc(16'hEFFF, 0, 1, 8'h04, 1, "R10 write without request");
        cyc(16'hEFFF, 0, 0, 8'h00, 1, "R10 idle");
        // Requests outside windows / no request
        cyc(16'h0200, 0, 0, 8'h00, 1, "R5 monitor addr without request");
        cyc(16'hEA00, 0, 0, 8'h00, 1, "R5 user addr without request");
        cyc(16'hD000, 1, 0, 8'h00, 1, "R5 outside windows");
        cyc(16'hF000, 1, 0, 8'h00, 1, "R5 above user window");
        cyc(16'h1000, 1, 0, 8'h00, 1, "R5 just above monitor window");
        cyc(16'hE7FF, 1, 0, 8'h00, 1, "R5 just below user window");
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule